// File: doc/BRIEF.md
# Dual Register File with Cross-Routed Bidirectional Ports

This block holds two independent register files, called file 0 and file 1. Each file has 16 words of 4 bits, its own 4-bit address and its own write enable. Two 4-bit data ports, A and B, reach the files through a routing switch.

Each port has two controls:
- A file-select bit chooses which file the port connects to.
- A direction bit chooses whether the port reads the file or writes it.

A port that is connected to a file always uses that file's address. The direction bits give four combinations: both ports reading, A writing while B reads, A reading while B writes, and both writing. When both ports write the same file, port B wins. When they write different files, each file is written from its own port.

A tri-state bus pin is represented by three signals per port: data-in, data-out and output-enable. Writes are captured on the rising clock edge. Reads are combinational from the current address.

Top module: `dual_regfile_router`

## Requirements
- R1: A synchronous active-low reset clears every word of both files to zero.
- R2: When port A is reading (`pa_write`=0), `pa_dout` shows the word of the file chosen by `pa_file` (0 = file 0, 1 = file 1) at that file's current address, in the same cycle.
- R3: When port B is reading (`pb_write`=0), `pb_dout` shows the word of the file chosen by `pb_file` at that file's current address, in the same cycle.
- R4: A port's output enable equals the inverse of its direction bit (direction 1 = write, output enable 0). While the enable is 0, that port's data-out is all zeros.
- R5: A file is written on the rising edge when three things hold: its write enable is 1, a writing port selects it, and reset is not active. The word written is the one at that file's address, and the data comes from that port.
- R6: When both ports are writing and select the same file, only port B's data is stored; port A's data is discarded.
- R7: When both ports are writing and select different files, both files are written on the same edge, each from its own port.
- R8: A file whose write enable is 1 but which no writing port selects keeps all its contents.
- R9: A file whose write enable is 0 keeps all its contents, even if a writing port selects it.
- R10: A word being written shows its old value on a reading port during the write cycle, and the new value from the next cycle on.
- R11: When both ports are reading and select the same file, both data-out buses carry the same word.
- R12: The address used to reach a file is that file's own address bus, whichever port is connected to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| f0_addr | input | 4 | Word address of file 0 |
| f0_wen | input | 1 | Write enable of file 0 |
| f1_addr | input | 4 | Word address of file 1 |
| f1_wen | input | 1 | Write enable of file 1 |
| pa_file | input | 1 | File chosen by port A (0 = file 0, 1 = file 1) |
| pb_file | input | 1 | File chosen by port B (0 = file 0, 1 = file 1) |
| pa_write | input | 1 | Port A direction (0 = read/drive, 1 = write/accept) |
| pb_write | input | 1 | Port B direction (0 = read/drive, 1 = write/accept) |
| pa_din | input | 4 | Data arriving on port A |
| pb_din | input | 4 | Data arriving on port B |
| pa_dout | output | 4 | Data driven by port A |
| pb_dout | output | 4 | Data driven by port B |
| pa_oe | output | 1 | Output enable of port A |
| pb_oe | output | 1 | Output enable of port B |

## Verification
The hardest case to reach from the ports is a collision that the port-B priority has to resolve. It needs both direction bits set, both selects pointing at one file, that file's write enable high, and different data on the two ports. Then a later cycle must expose the stored word through a reading port, which means turning a port's direction back to read.

Directed sequences set up exactly this case, and also the case where the two writes split across the files. A long run of random control and data words then compares every cycle against a behavioural model of both files. That random run also covers enables that arrive with no writing port, reads that fall in the same cycle as a write, and writes made with one file's address while the other file is being read.

// File: rtl/dualrf_pkg.sv
// Package: shared constants and types for the dual register file.
// Assumes exactly two files, so one select bit reaches every file.
package dualrf_pkg;
    localparam int NUM_FILES = 2;
    localparam int SEL_W     = 1;

    typedef logic [SEL_W-1:0] file_sel_t;

    // Direction of a data port: drive stored data out, or accept data in.
    typedef enum logic {
        PORT_DRIVE  = 1'b0,
        PORT_ACCEPT = 1'b1
    } port_mode_e;
endpackage

// File: rtl/dualrf_decoder.sv
// Module: binary to one-hot word decoder.
// Exactly one output bit is set for every address below DEPTH.
// Assumes DEPTH does not exceed 2**ADDR_W.
module dualrf_decoder #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  word_hit
);
    genvar w;
    generate
        for (w = 0; w < DEPTH; w++) begin : g_hit
            // Purpose: compare the address with this word's index.
            assign word_hit[w] = (addr == ADDR_W'(w));
        end
    endgenerate
endmodule

// File: rtl/dualrf_bank.sv
// Module: one register file of DEPTH words of DATA_W bits.
// Writes happen on the rising clock edge; reads are combinational.
// A write is not forwarded to the read port in the same cycle.
// Assumes a synchronous active-low reset that clears every word.
module dualrf_bank #(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DEPTH-1:0]             word_hit;
    logic [DEPTH-1:0][DATA_W-1:0] word_bus;

    dualrf_decoder #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_decoder (
        .addr     (addr),
        .word_hit (word_hit)
    );

    genvar w;
    generate
        for (w = 0; w < DEPTH; w++) begin : g_word
            logic [DATA_W-1:0] word_q;

            // Purpose: clear on reset, else load this word when it is addressed and enabled.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_en && word_hit[w]) begin
                    word_q <= wr_data;
                end
            end

            assign word_bus[w] = word_q;
        end
    endgenerate

    // Purpose: select the addressed word with an AND-OR over the one-hot hits.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (word_hit[i]) begin
                rd_data = rd_data | word_bus[i];
            end
        end
    end
endmodule

// File: rtl/dualrf_write_arbiter.sv
// Module: turns port routing, port direction and file enables into per-file write strobes.
// A file is written only when its enable is set and some accepting port selects it.
// When both ports accept data for the same file, port B's data is used.
module dualrf_write_arbiter
    import dualrf_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  file_sel_t                        pa_sel,
    input  file_sel_t                        pb_sel,
    input  port_mode_e                       pa_mode,
    input  port_mode_e                       pb_mode,
    input  logic [DATA_W-1:0]                pa_data,
    input  logic [DATA_W-1:0]                pb_data,
    input  logic [NUM_FILES-1:0]             file_wen,
    output logic [NUM_FILES-1:0]             bank_we,
    output logic [NUM_FILES-1:0][DATA_W-1:0] bank_wdata
);
    genvar f;
    generate
        for (f = 0; f < NUM_FILES; f++) begin : g_file
            logic a_claims;
            logic b_claims;

            // Purpose: find which accepting ports are routed to this file.
            assign a_claims = (pa_mode == PORT_ACCEPT) && (pa_sel == SEL_W'(f));
            assign b_claims = (pb_mode == PORT_ACCEPT) && (pb_sel == SEL_W'(f));

            // Purpose: the strobe needs the enable and at least one claimant.
            assign bank_we[f] = file_wen[f] && (a_claims || b_claims);

            // Purpose: port B's data takes precedence over port A's.
            assign bank_wdata[f] = b_claims ? pb_data : pa_data;
        end
    endgenerate
endmodule

// File: rtl/dualrf_port_driver.sv
// Module: output side of one data port.
// Picks the selected file's read data and produces the output enable from the direction.
// Drives zeros when the port is accepting, so a disabled bus carries no stale data.
module dualrf_port_driver
    import dualrf_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  file_sel_t                        sel,
    input  port_mode_e                       mode,
    input  logic [NUM_FILES-1:0][DATA_W-1:0] bank_rdata,
    output logic [DATA_W-1:0]                dout,
    output logic                             oe
);
    // Purpose: the driver is enabled only in drive mode.
    assign oe = (mode == PORT_DRIVE);

    // Purpose: route the chosen file's word out, gated by the enable.
    always_comb begin
        dout = '0;
        if (oe) begin
            dout = bank_rdata[sel];
        end
    end
endmodule

// File: rtl/dual_regfile_router.sv
// Module: top of the dual register file.
// Contains two banks, a write arbiter and two port drivers.
// Each bank is addressed by its own address bus, whichever port reaches it.
// Tri-state ports are represented by separate data-in, data-out and enable buses.
module dual_regfile_router
    import dualrf_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] f0_addr,
    input  logic              f0_wen,
    input  logic [ADDR_W-1:0] f1_addr,
    input  logic              f1_wen,
    input  logic              pa_file,
    input  logic              pb_file,
    input  logic              pa_write,
    input  logic              pb_write,
    input  logic [DATA_W-1:0] pa_din,
    input  logic [DATA_W-1:0] pb_din,
    output logic [DATA_W-1:0] pa_dout,
    output logic [DATA_W-1:0] pb_dout,
    output logic              pa_oe,
    output logic              pb_oe
);
    logic [NUM_FILES-1:0][ADDR_W-1:0] bank_addr;
    logic [NUM_FILES-1:0]             file_wen;
    logic [NUM_FILES-1:0]             bank_we;
    logic [NUM_FILES-1:0][DATA_W-1:0] bank_wdata;
    logic [NUM_FILES-1:0][DATA_W-1:0] bank_rdata;
    port_mode_e                       pa_mode;
    port_mode_e                       pb_mode;
    file_sel_t                        pa_sel;
    file_sel_t                        pb_sel;

    // Purpose: collect the per-file controls into indexed buses.
    assign bank_addr[0] = f0_addr;
    assign bank_addr[1] = f1_addr;
    assign file_wen     = {f1_wen, f0_wen};

    // Purpose: give the raw control pins their typed meaning.
    assign pa_mode = port_mode_e'(pa_write);
    assign pb_mode = port_mode_e'(pb_write);
    assign pa_sel  = file_sel_t'(pa_file);
    assign pb_sel  = file_sel_t'(pb_file);

    dualrf_write_arbiter #(
        .DATA_W (DATA_W)
    ) u_arbiter (
        .pa_sel     (pa_sel),
        .pb_sel     (pb_sel),
        .pa_mode    (pa_mode),
        .pb_mode    (pb_mode),
        .pa_data    (pa_din),
        .pb_data    (pb_din),
        .file_wen   (file_wen),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata)
    );

    genvar f;
    generate
        for (f = 0; f < NUM_FILES; f++) begin : g_bank
            dualrf_bank #(
                .DATA_W (DATA_W),
                .DEPTH  (DEPTH),
                .ADDR_W (ADDR_W)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .addr    (bank_addr[f]),
                .wr_en   (bank_we[f]),
                .wr_data (bank_wdata[f]),
                .rd_data (bank_rdata[f])
            );
        end
    endgenerate

    dualrf_port_driver #(
        .DATA_W (DATA_W)
    ) u_drv_a (
        .sel        (pa_sel),
        .mode       (pa_mode),
        .bank_rdata (bank_rdata),
        .dout       (pa_dout),
        .oe         (pa_oe)
    );

    dualrf_port_driver #(
        .DATA_W (DATA_W)
    ) u_drv_b (
        .sel        (pb_sel),
        .mode       (pb_mode),
        .bank_rdata (bank_rdata),
        .dout       (pb_dout),
        .oe         (pb_oe)
    );
endmodule

// File: rtl/dualrf_checks.sv
// Module: temporal checks for dual_regfile_router, attached with bind.
// Observes the top's ports and the read data of both banks.
module dualrf_checks #(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       f0_addr,
    input logic                    f0_wen,
    input logic [ADDR_W-1:0]       f1_addr,
    input logic                    f1_wen,
    input logic                    pa_file,
    input logic                    pb_file,
    input logic                    pa_write,
    input logic                    pb_write,
    input logic [DATA_W-1:0]       pa_din,
    input logic [DATA_W-1:0]       pb_din,
    input logic [DATA_W-1:0]       pa_dout,
    input logic [DATA_W-1:0]       pb_dout,
    input logic                    pa_oe,
    input logic                    pb_oe,
    input logic [1:0][DATA_W-1:0]  rdata
);
    logic [1:0][ADDR_W-1:0] addr_v;
    logic [1:0]             wen_v;

    assign addr_v = {f1_addr, f0_addr};
    assign wen_v  = {f1_wen, f0_wen};

    assert_a_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pa_oe |-> (pa_dout == rdata[pa_file]));

    assert_b_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pb_oe |-> (pb_dout == rdata[pb_file]));

    assert_a_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pa_write |-> (!pa_oe && pa_dout == '0));

    assert_b_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pb_write |-> (!pb_oe && pb_dout == '0));

    assert_drive_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pa_write && !pb_write) |-> (pa_oe && pb_oe));

    assert_shared_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pa_write && !pb_write && pa_file == pb_file) |-> (pa_dout == pb_dout));

    genvar f;
    generate
        for (f = 0; f < 2; f++) begin : g_file
            logic a_in;
            logic b_in;
            assign a_in = pa_write && (pa_file == 1'(f));
            assign b_in = pb_write && (pb_file == 1'(f));

            assert_a_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (wen_v[f] && a_in && !b_in) |=>
                    (!$stable(addr_v[f]) || rdata[f] == $past(pa_din)));

            assert_b_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (wen_v[f] && b_in) |=>
                    (!$stable(addr_v[f]) || rdata[f] == $past(pb_din)));

            assert_unrouted_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (wen_v[f] && !a_in && !b_in) |=>
                    (!$stable(addr_v[f]) || $stable(rdata[f])));

            assert_no_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (!wen_v[f]) |=> (!$stable(addr_v[f]) || $stable(rdata[f])));
        end
    endgenerate
endmodule

bind dual_regfile_router dualrf_checks #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .f0_addr  (f0_addr),
    .f0_wen   (f0_wen),
    .f1_addr  (f1_addr),
    .f1_wen   (f1_wen),
    .pa_file  (pa_file),
    .pb_file  (pb_file),
    .pa_write (pa_write),
    .pb_write (pb_write),
    .pa_din   (pa_din),
    .pb_din   (pb_din),
    .pa_dout  (pa_dout),
    .pb_dout  (pb_dout),
    .pa_oe    (pa_oe),
    .pb_oe    (pb_oe),
    .rdata    (bank_rdata)
);

// File: tb/dual_regfile_router_bench.sv
module dual_regfile_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 4;
    localparam int DEPTH      = 16;
    localparam int AW         = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] f0_addr, f1_addr;
    logic          f0_wen, f1_wen;
    logic          pa_file, pb_file, pa_write, pb_write;
    logic [DW-1:0] pa_din, pb_din, pa_dout, pb_dout;
    logic          pa_oe, pb_oe;

    int ref_mem [2][DEPTH];
    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    dual_regfile_router #(.DATA_W(DW), .DEPTH(DEPTH), .ADDR_W(AW)) u_dual_regfile_router (
        .clk(clk), .rst_n(rst_n),
        .f0_addr(f0_addr), .f0_wen(f0_wen), .f1_addr(f1_addr), .f1_wen(f1_wen),
        .pa_file(pa_file), .pb_file(pb_file), .pa_write(pa_write), .pb_write(pb_write),
        .pa_din(pa_din), .pb_din(pb_din), .pa_dout(pa_dout), .pb_dout(pb_dout),
        .pa_oe(pa_oe), .pb_oe(pb_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int file_addr(int f);
        return (f == 0) ? int'(f0_addr) : int'(f1_addr);
    endfunction

    // Outputs predicted from the model before the coming edge.
    task automatic compare_all();
        int exp_a, exp_b;
        exp_a = pa_write ? 0 : ref_mem[pa_file][file_addr(pa_file)];
        exp_b = pb_write ? 0 : ref_mem[pb_file][file_addr(pb_file)];
        check(pa_write ? "R4" : "R2", "pa_dout", int'(pa_dout), exp_a);
        check(pb_write ? "R4" : "R3", "pb_dout", int'(pb_dout), exp_b);
        check("R4", "pa_oe", int'(pa_oe), int'(!pa_write));
        check("R4", "pb_oe", int'(pb_oe), int'(!pb_write));
    endtask

    // Model write rules: enable plus an accepting port on the file, port B first.
    task automatic model_edge();
        for (int f = 0; f < 2; f++) begin
            bit a_hit, b_hit, wen;
            a_hit = pa_write && (int'(pa_file) == f);
            b_hit = pb_write && (int'(pb_file) == f);
            wen   = (f == 0) ? f0_wen : f1_wen;
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) ref_mem[f][w] = 0;
            end else if (wen && (a_hit || b_hit)) begin
                ref_mem[f][file_addr(f)] = b_hit ? int'(pb_din) : int'(pa_din);
            end
        end
    endtask

    task automatic step();
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic drive(int a0, int w0, int a1, int w1, int sa, int sb,
                         int da, int db, int ia, int ib);
        f0_addr  = AW'(a0); f0_wen  = w0[0];
        f1_addr  = AW'(a1); f1_wen  = w1[0];
        pa_file  = sa[0];   pb_file  = sb[0];
        pa_write = da[0];   pb_write = db[0];
        pa_din   = DW'(ia); pb_din   = DW'(ib);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < 2; f++)
            for (int w = 0; w < DEPTH; w++) ref_mem[f][w] = 0;
        rst_n = 1'b0;
        drive(0, 1, 0, 1, 0, 1, 1, 1, 15, 15);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every word of both files reads zero after reset.
        for (int i = 0; i < DEPTH; i++) begin
            drive(i, 0, i, 0, 0, 1, 0, 0, 0, 0);
            check("R1", "file0 word", int'(pa_dout), 0);
            check("R1", "file1 word", int'(pb_dout), 0);
            step();
        end

        // R5: port A writes 9 into file 0 word 3.
        drive(3, 1, 0, 0, 0, 1, 1, 0, 9, 0);
        step();
        drive(3, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        check("R5", "file0[3] via B", int'(pb_dout), 9);
        check("R2", "file1[0] via A", int'(pa_dout), 0);
        step();

        // R12: port B writes 5 into file 1 word 7 using file 1's own address.
        drive(3, 0, 7, 1, 0, 1, 0, 1, 0, 5);
        step();
        drive(7, 0, 7, 0, 1, 0, 0, 0, 0, 0);
        check("R12", "file1[7] via A", int'(pa_dout), 5);
        check("R12", "file0[7] via B", int'(pb_dout), 0);
        step();

        // R6: both ports write file 0 word 2, port B's 6 wins over A's 10.
        drive(2, 1, 0, 0, 0, 0, 1, 1, 10, 6);
        step();
        drive(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R6", "file0[2]", int'(pa_dout), 6);
        step();

        // R7: A writes 12 to file 1, B writes 3 to file 0, both at word 5.
        drive(5, 1, 5, 1, 1, 0, 1, 1, 12, 3);
        step();
        drive(5, 0, 5, 0, 0, 1, 0, 0, 0, 0);
        check("R7", "file0[5]", int'(pa_dout), 3);
        check("R7", "file1[5]", int'(pb_dout), 12);
        step();

        // R8: enables high, both ports reading, so no file is written.
        drive(3, 1, 7, 1, 0, 1, 0, 0, 15, 15);
        step();
        check("R8", "file0[3]", int'(pa_dout), 9);
        check("R8", "file1[7]", int'(pb_dout), 5);
        // R8: file 0 enabled, but the only accepting port is on file 1.
        drive(3, 1, 7, 0, 1, 0, 1, 0, 15, 15);
        step();
        drive(3, 0, 7, 0, 0, 1, 0, 0, 0, 0);
        check("R8", "file0[3] after", int'(pa_dout), 9);
        check("R9", "file1[7] after", int'(pb_dout), 5);
        step();

        // R9: port A accepts for file 0 with its enable low.
        drive(3, 0, 7, 0, 0, 1, 1, 0, 14, 0);
        step();
        drive(3, 0, 7, 0, 0, 0, 0, 0, 0, 0);
        check("R9", "file0[3]", int'(pa_dout), 9);
        step();

        // R10: write 2 to file 0 word 3 while port B reads it.
        drive(3, 1, 0, 0, 0, 0, 1, 0, 2, 0);
        check("R10", "old value", int'(pb_dout), 9);
        step();
        check("R10", "new value", int'(pb_dout), 2);

        // R11: both ports read file 0 word 3.
        drive(3, 0, 7, 0, 0, 0, 0, 0, 0, 0);
        check("R11", "pa_dout", int'(pa_dout), 2);
        check("R11", "pb_dout", int'(pb_dout), 2);
        step();

        // R4: an accepting port drives nothing.
        drive(3, 0, 7, 0, 0, 0, 1, 1, 7, 7);
        check("R4", "pa_oe accepting", int'(pa_oe), 0);
        check("R4", "pb_dout accepting", int'(pb_dout), 0);
        step();

        // Random sweep, checked against the model every cycle (R2..R12).
        for (int n = 0; n < 2000; n++) begin
            drive($urandom_range(15), $urandom_range(1), $urandom_range(15),
                  $urandom_range(1), $urandom_range(1), $urandom_range(1),
                  $urandom_range(1), $urandom_range(1), $urandom_range(15),
                  $urandom_range(15));
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule